// File: doc/BRIEF.md
# Two-Phase Layered Multiply Step Sequencer

This block sequences one elementary time-domain multiply step on a stacked, layered weight memory. A single command names a starting weight layer, how many consecutive layers to process (one to four), the tile row and column enables, a layer-select settling count, an integration count and a coupling stretch fraction. For each layer the block pulses a load-capacitor reset, selects the weight layer and waits for it to settle, and opens the integration window. At the start of that window it pulses the input-encoder launch. It then switches the read selection to the top (sweep) layer, waits again for settling, and opens the output window. During the output window every input line is driven and the output accumulators count.

While a step is in progress exactly one layer is in read mode and all others are held in pass mode. The output window is always longer than the integration window by a coupling stretch. Results from up to four layers are summed in the downstream accumulators, which are cleared only before the first layer. A one-cycle done pulse marks the end of the operation. Commands that arrive while the block is busy are dropped.

Top module: `vmm_step_seq`

## Requirements
- R1: After reset, and whenever idle, every output is low and no layer is selected (`layer_sel` all zero).
- R2: For each layer the phases follow in fixed order: one cycle of `cap_rst`, then `t_ls` cycles selecting the weight layer, then `t_int` cycles of `integ_win` with `enc_start` high only in the first of them, then `t_ls` cycles selecting the top layer, then the output window with `drive_all` and `acc_en` high, then one gap cycle.
- R3: One layer step lasts 2·t_ls + t_int + W cycles of selected-layer activity (W is the output window length), plus one reset cycle before and one gap cycle after.
- R4: The output window length W equals Te + max(1, floor(Te·coup_frac/16)), where Te is the effective integration count, so W is always greater than Te.
- R5: A `t_ls` or `t_int` value of zero is treated as one cycle.
- R6: `layer_sel` is one-hot (bit i selects layer i) whenever `vmm_mode` is high and all zero otherwise. During top-layer select and the output window it selects layer NUM_LAYERS-1.
- R7: `extra_layers` = n processes n+1 layers, at indices base, base+1, … with wrap from NUM_LAYERS-1 to 0.
- R8: `acc_clr` is high only during the reset cycle of the first layer of an operation.
- R9: `done` is high for exactly one cycle, the cycle after the gap cycle that follows the last output window; `busy` then drops.
- R10: A `start` while `busy` is high has no effect on the running operation, its parameters or what follows it.
- R11: `tile_en` bit r·NUM_COLS+c equals `row_en[r] & col_en[c]` as captured at start, and it is driven only while `vmm_mode` is high.
- R12: `vmm_mode` is high from the first weight-select cycle through the last output-window cycle of each layer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Command strobe, accepted only when idle |
| base_layer | input | LAYER_W | First weight layer index |
| extra_layers | input | 2 | Number of layers minus one |
| row_en | input | NUM_ROWS | Tile row enables |
| col_en | input | NUM_COLS | Tile column enables |
| t_ls | input | CNT_W | Layer-select settling cycles |
| t_int | input | CNT_W | Integration window cycles |
| coup_frac | input | FRAC_W | Coupling stretch fraction in sixteenths |
| layer_sel | output | NUM_LAYERS | One-hot read-layer select |
| cap_rst | output | 1 | Load capacitor reset |
| vmm_mode | output | 1 | Capacitors tied to bit lines for the operation |
| enc_start | output | 1 | Input encoder launch pulse |
| integ_win | output | 1 | Integration window |
| drive_all | output | 1 | Sweep: all input lines enabled |
| acc_clr | output | 1 | Output accumulator clear |
| acc_en | output | 1 | Output accumulator count enable |
| tile_en | output | NUM_ROWS·NUM_COLS | Tile enables |
| busy | output | 1 | Operation in progress |
| done | output | 1 | End-of-operation pulse |

## Verification
The assertions assume that `start` and the other inputs are known, two-valued levels sampled at the clock edge, so that a rise of `busy` can be traced to a strobe one cycle earlier. The stimulus changes inputs only on falling edges, holds each strobe for exactly one cycle, and keeps all counts small so that every phase boundary, including zero counts, the wrap past the top layer and a strobe injected mid-operation, is visited in full.

// File: rtl/vmm_seq_pkg.sv
// Shared types for the layered multiply step sequencer.
// Assumes: state encoding is private to the sequencer and its top.
package vmm_seq_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_RESET,
        S_SEL_W,
        S_INTEG,
        S_SEL_SW,
        S_SWEEP,
        S_NEXT,
        S_DONE
    } seq_state_e;
endpackage

// File: rtl/vmm_win_scaler.sv
// Output-window length from the integration count and a coupling fraction.
// Window = Te + max(1, floor(Te*frac / 2^FRAC_W)), Te = max(1, t_int).
// Assumes: result fits CNT_W+1 bits, which holds since frac < 2^FRAC_W.
module vmm_win_scaler #(
    parameter int CNT_W  = 12,
    parameter int FRAC_W = 4
) (
    input  logic [CNT_W-1:0]  t_int_in,
    input  logic [FRAC_W-1:0] frac_in,
    output logic [CNT_W-1:0]  t_int_eff,
    output logic [CNT_W:0]    win_out
);
    localparam int PROD_W = CNT_W + FRAC_W;

    logic [PROD_W-1:0] prod;
    logic [CNT_W-1:0]  stretch;

    // Scale the effective integration count and add a stretch of at least one.
    always_comb begin
        t_int_eff = (t_int_in == '0) ? CNT_W'(1) : t_int_in;
        prod      = {{FRAC_W{1'b0}}, t_int_eff} * {{CNT_W{1'b0}}, frac_in};
        stretch   = prod[PROD_W-1:FRAC_W];
        if (stretch == '0) begin
            stretch = CNT_W'(1);
        end
        win_out   = {1'b0, t_int_eff} + {1'b0, stretch};
    end
endmodule

// File: rtl/vmm_layer_dec.sv
// Index to one-hot layer select with a global enable.
// Assumes: idx < NUM_LAYERS; with en low every layer stays in pass mode.
module vmm_layer_dec #(
    parameter int NUM_LAYERS = 64,
    parameter int LAYER_W    = $clog2(NUM_LAYERS)
) (
    input  logic               en,
    input  logic [LAYER_W-1:0] idx,
    output logic [NUM_LAYERS-1:0] sel
);
    for (genvar g = 0; g < NUM_LAYERS; g++) begin : g_line
        // Each line compares against its own constant index.
        assign sel[g] = en && (idx == LAYER_W'(g));
    end
endmodule

// File: rtl/vmm_tile_grid.sv
// Tile enable grid: a tile is on where its row and column lines cross.
// Assumes: bit r*NUM_COLS+c addresses the tile at row r, column c.
module vmm_tile_grid #(
    parameter int NUM_ROWS = 4,
    parameter int NUM_COLS = 4
) (
    input  logic                         en,
    input  logic [NUM_ROWS-1:0]          row_en,
    input  logic [NUM_COLS-1:0]          col_en,
    output logic [NUM_ROWS*NUM_COLS-1:0] tile_en
);
    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
            // Crossing of one row line and one column line.
            assign tile_en[r*NUM_COLS+c] = en && row_en[r] && col_en[c];
        end
    end
endmodule

// File: rtl/vmm_seq_ctrl.sv
// Phase sequencer: state, phase counter and layer walk for one operation.
// Latches all timing and layer parameters when a command is accepted in
// idle; commands at any other time are ignored.
// Assumes: win_in >= 1 and t_int_in >= 1 (supplied by the scaler).
module vmm_seq_ctrl
    import vmm_seq_pkg::*;
#(
    parameter int NUM_LAYERS = 64,
    parameter int LAYER_W    = $clog2(NUM_LAYERS),
    parameter int CNT_W      = 12,
    parameter int ACC_W      = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CNT_W-1:0]   t_ls_in,
    input  logic [CNT_W-1:0]   t_int_in,
    input  logic [CNT_W:0]     win_in,
    input  logic [LAYER_W-1:0] base_in,
    input  logic [ACC_W-1:0]   extra_in,
    output seq_state_e         state,
    output logic               launch,
    output logic [LAYER_W-1:0] cur_layer,
    output logic               first_layer
);
    localparam logic [CNT_W:0]   ONE_C   = (CNT_W+1)'(1);
    localparam logic [LAYER_W-1:0] TOP_IX = LAYER_W'(NUM_LAYERS - 1);

    logic [CNT_W-1:0] tls_q, tint_q;
    logic [CNT_W:0]   win_q, cnt;
    logic [ACC_W-1:0] extra_q, lay_cnt;
    logic             cnt_zero;

    // Command acceptance and phase-counter expiry.
    always_comb begin
        launch      = (state == S_IDLE) && start;
        cnt_zero    = (cnt == '0);
        first_layer = (lay_cnt == '0);
    end

    // Parameter capture at acceptance; held for the whole operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tls_q   <= CNT_W'(1);
            tint_q  <= CNT_W'(1);
            win_q   <= ONE_C;
            extra_q <= '0;
        end else if (launch) begin
            tls_q   <= (t_ls_in == '0) ? CNT_W'(1) : t_ls_in;
            tint_q  <= t_int_in;
            win_q   <= win_in;
            extra_q <= extra_in;
        end
    end

    // Phase state machine with a down-counter per timed phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            cnt       <= '0;
            lay_cnt   <= '0;
            cur_layer <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start) begin
                        state     <= S_RESET;
                        lay_cnt   <= '0;
                        cur_layer <= base_in;
                    end
                end
                S_RESET: begin
                    state <= S_SEL_W;
                    cnt   <= {1'b0, tls_q} - ONE_C;
                end
                S_SEL_W: begin
                    if (cnt_zero) begin
                        state <= S_INTEG;
                        cnt   <= {1'b0, tint_q} - ONE_C;
                    end else begin
                        cnt <= cnt - ONE_C;
                    end
                end
                S_INTEG: begin
                    if (cnt_zero) begin
                        state <= S_SEL_SW;
                        cnt   <= {1'b0, tls_q} - ONE_C;
                    end else begin
                        cnt <= cnt - ONE_C;
                    end
                end
                S_SEL_SW: begin
                    if (cnt_zero) begin
                        state <= S_SWEEP;
                        cnt   <= win_q - ONE_C;
                    end else begin
                        cnt <= cnt - ONE_C;
                    end
                end
                S_SWEEP: begin
                    if (cnt_zero) begin
                        state <= S_NEXT;
                    end else begin
                        cnt <= cnt - ONE_C;
                    end
                end
                S_NEXT: begin
                    if (lay_cnt == extra_q) begin
                        state <= S_DONE;
                    end else begin
                        state     <= S_RESET;
                        lay_cnt   <= lay_cnt + ACC_W'(1);
                        cur_layer <= (cur_layer == TOP_IX) ? '0
                                                           : cur_layer + LAYER_W'(1);
                    end
                end
                S_DONE: begin
                    state <= S_IDLE;
                end
                default: begin
                    state <= S_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/vmm_step_seq.sv
// Top of the two-phase layered multiply step sequencer.
// Decodes the sequencer state into the capacitor reset, read-layer select,
// encoder launch, windows, accumulator controls, tile enables and done.
// Assumes: the top layer (NUM_LAYERS-1) holds the sweep current sources.
module vmm_step_seq
    import vmm_seq_pkg::*;
#(
    parameter int NUM_LAYERS = 64,
    parameter int NUM_ROWS   = 4,
    parameter int NUM_COLS   = 4,
    parameter int CNT_W      = 12,
    parameter int FRAC_W     = 4,
    parameter int LAYER_W    = $clog2(NUM_LAYERS),
    parameter int TILES      = NUM_ROWS * NUM_COLS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [LAYER_W-1:0]    base_layer,
    input  logic [1:0]            extra_layers,
    input  logic [NUM_ROWS-1:0]   row_en,
    input  logic [NUM_COLS-1:0]   col_en,
    input  logic [CNT_W-1:0]      t_ls,
    input  logic [CNT_W-1:0]      t_int,
    input  logic [FRAC_W-1:0]     coup_frac,
    output logic [NUM_LAYERS-1:0] layer_sel,
    output logic                  cap_rst,
    output logic                  vmm_mode,
    output logic                  enc_start,
    output logic                  integ_win,
    output logic                  drive_all,
    output logic                  acc_clr,
    output logic                  acc_en,
    output logic [TILES-1:0]      tile_en,
    output logic                  busy,
    output logic                  done
);
    localparam logic [LAYER_W-1:0] TOP_IX = LAYER_W'(NUM_LAYERS - 1);

    seq_state_e           state;
    logic                 launch, first_layer, integ_q, on_top;
    logic [LAYER_W-1:0]   cur_layer, read_idx;
    logic [CNT_W-1:0]     t_int_eff;
    logic [CNT_W:0]       win_len;
    logic [NUM_ROWS-1:0]  row_q;
    logic [NUM_COLS-1:0]  col_q;

    vmm_win_scaler #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_scale (
        .t_int_in  (t_int),
        .frac_in   (coup_frac),
        .t_int_eff (t_int_eff),
        .win_out   (win_len)
    );

    vmm_seq_ctrl #(
        .NUM_LAYERS(NUM_LAYERS), .LAYER_W(LAYER_W), .CNT_W(CNT_W), .ACC_W(2)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .t_ls_in     (t_ls),
        .t_int_in    (t_int_eff),
        .win_in      (win_len),
        .base_in     (base_layer),
        .extra_in    (extra_layers),
        .state       (state),
        .launch      (launch),
        .cur_layer   (cur_layer),
        .first_layer (first_layer)
    );

    // Tile line capture at command acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else if (launch) begin
            row_q <= row_en;
            col_q <= col_en;
        end
    end

    // Previous-cycle integration flag for the encoder launch edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            integ_q <= 1'b0;
        end else begin
            integ_q <= (state == S_INTEG);
        end
    end

    // State decode into the phase controls.
    always_comb begin
        cap_rst   = (state == S_RESET);
        acc_clr   = (state == S_RESET) && first_layer;
        integ_win = (state == S_INTEG);
        enc_start = (state == S_INTEG) && !integ_q;
        drive_all = (state == S_SWEEP);
        acc_en    = (state == S_SWEEP);
        on_top    = (state == S_SEL_SW) || (state == S_SWEEP);
        vmm_mode  = (state == S_SEL_W) || (state == S_INTEG) || on_top;
        read_idx  = on_top ? TOP_IX : cur_layer;
        busy      = (state != S_IDLE);
        done      = (state == S_DONE);
    end

    vmm_layer_dec #(.NUM_LAYERS(NUM_LAYERS), .LAYER_W(LAYER_W)) u_dec (
        .en  (vmm_mode),
        .idx (read_idx),
        .sel (layer_sel)
    );

    vmm_tile_grid #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)) u_grid (
        .en      (vmm_mode),
        .row_en  (row_q),
        .col_en  (col_q),
        .tile_en (tile_en)
    );
endmodule

// File: rtl/vmm_step_seq_chk.sv
// Property checker for the step sequencer, bound to every instance.
// Assumes: inputs are known two-valued levels at each clock edge.
module vmm_step_seq_chk #(
    parameter int NUM_LAYERS = 64
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic                  busy,
    input logic                  done,
    input logic                  cap_rst,
    input logic                  acc_clr,
    input logic                  vmm_mode,
    input logic                  enc_start,
    input logic                  integ_win,
    input logic                  drive_all,
    input logic [NUM_LAYERS-1:0] layer_sel
);
    // R6
    sel_onehot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(layer_sel));

    // R6
    sel_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vmm_mode |-> ($countones(layer_sel) == 1));

    // R6
    sweep_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_all |-> layer_sel[NUM_LAYERS-1]);

    // R2
    integ_to_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(integ_win) |-> (vmm_mode && layer_sel[NUM_LAYERS-1]));

    // R2
    reset_to_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_rst |=> (vmm_mode && !integ_win && !drive_all));

    // R2
    enc_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_start |-> integ_win);

    // R8
    clr_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clr |-> cap_rst);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_after_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(drive_all, 2));

    // R10
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

bind vmm_step_seq vmm_step_seq_chk #(.NUM_LAYERS(NUM_LAYERS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .cap_rst   (cap_rst),
    .acc_clr   (acc_clr),
    .vmm_mode  (vmm_mode),
    .enc_start (enc_start),
    .integ_win (integ_win),
    .drive_all (drive_all),
    .layer_sel (layer_sel)
);

// File: tb/tb_vmm_step_seq.sv
// Directed bench for the step sequencer: a cycle-by-cycle expected trace is
// built from the requirements and compared at falling edges.
module tb_vmm_step_seq;
    localparam int NL = 64;
    localparam int NR = 4;
    localparam int NC = 4;
    localparam int CW = 12;
    localparam int FW = 4;
    localparam int LW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [LW-1:0] base_layer = '0;
    logic [1:0]    extra_layers = '0;
    logic [NR-1:0] row_en = '0;
    logic [NC-1:0] col_en = '0;
    logic [CW-1:0] t_ls = '0;
    logic [CW-1:0] t_int = '0;
    logic [FW-1:0] coup_frac = '0;
    logic [NL-1:0] layer_sel;
    logic          cap_rst, vmm_mode, enc_start, integ_win, drive_all;
    logic          acc_clr, acc_en, busy, done;
    logic [NR*NC-1:0] tile_en;

    int errors = 0;
    int checks = 0;
    int cyc_i = 0;
    int inj_at = -1;

    always #2 clk = ~clk;   // 250 MHz

    vmm_step_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_layer(base_layer),
        .extra_layers(extra_layers), .row_en(row_en), .col_en(col_en),
        .t_ls(t_ls), .t_int(t_int), .coup_frac(coup_frac),
        .layer_sel(layer_sel), .cap_rst(cap_rst), .vmm_mode(vmm_mode),
        .enc_start(enc_start), .integ_win(integ_win), .drive_all(drive_all),
        .acc_clr(acc_clr), .acc_en(acc_en), .tile_en(tile_en),
        .busy(busy), .done(done)
    );

    task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: got %h expected %h", tag, cyc_i, got, exp);
        end
    endtask

    // kind: 0 reset,1 weight select,2 integrate,3 top select,4 sweep,5 gap,6 done,7 idle
    task automatic expect_cycle(input int kind, input int lay, input bit first,
                                input bit enc, input logic [NR*NC-1:0] tiles);
        logic [8:0] got, exp;
        logic [NL-1:0] lexp;
        string tag;
        @(negedge clk);
        got = {cap_rst, acc_clr, vmm_mode, enc_start, integ_win, drive_all, acc_en, done, busy};
        exp = {kind == 0, kind == 0 && first, kind >= 1 && kind <= 4, kind == 2 && enc,
               kind == 2, kind == 4, kind == 4, kind == 6, kind != 7};
        case (kind)
            0: tag = "R2 R8 reset";
            1: tag = "R2 R12 weight-select";
            2: tag = "R2 R3 integrate";
            3: tag = "R3 R6 top-select";
            4: tag = "R4 R2 sweep";
            5: tag = "R3 gap";
            6: tag = "R9 done";
            default: tag = "R10 R1 idle";
        endcase
        check(tag, 128'(got), 128'(exp));
        lexp = (kind == 1 || kind == 2) ? (NL'(1) << lay) :
               (kind == 3 || kind == 4) ? (NL'(1) << (NL - 1)) : '0;
        check({tag, " R6 R7 layer_sel"}, 128'(layer_sel), 128'(lexp));
        check({tag, " R11 tile_en"}, 128'(tile_en),
              128'((kind >= 1 && kind <= 4) ? tiles : '0));
        if (cyc_i == 0) start = 1'b0;
        if (inj_at >= 0 && cyc_i == inj_at) begin
            start = 1'b1; base_layer = 6'd40; extra_layers = 2'd0;
            t_ls = 12'd9; t_int = 12'd9; coup_frac = 4'd1;
            row_en = 4'b1111; col_en = 4'b1111;
        end
        if (inj_at >= 0 && cyc_i == inj_at + 1) start = 1'b0;
        cyc_i++;
    endtask

    task automatic run_op(input int base, input int extra, input int tls, input int tint,
                          input int frac, input logic [NR-1:0] rows,
                          input logic [NC-1:0] cols, input int inject);
        int tls_e, tint_e, st, win;
        logic [NR*NC-1:0] tiles;
        tls_e  = (tls == 0) ? 1 : tls;                 // R5
        tint_e = (tint == 0) ? 1 : tint;               // R5
        st     = (tint_e * frac) / 16;
        win    = tint_e + ((st == 0) ? 1 : st);        // R4
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++)
                tiles[r*NC+c] = rows[r] & cols[c];     // R11
        @(negedge clk);
        start = 1'b1; base_layer = LW'(base); extra_layers = 2'(extra);
        t_ls = CW'(tls); t_int = CW'(tint); coup_frac = FW'(frac);
        row_en = rows; col_en = cols;
        cyc_i = 0; inj_at = inject;
        for (int k = 0; k <= extra; k++) begin         // R7
            int lay = (base + k) % NL;
            expect_cycle(0, lay, k == 0, 1'b0, tiles);
            for (int i = 0; i < tls_e; i++) expect_cycle(1, lay, 1'b0, 1'b0, tiles);
            for (int i = 0; i < tint_e; i++) expect_cycle(2, lay, 1'b0, i == 0, tiles);
            for (int i = 0; i < tls_e; i++) expect_cycle(3, lay, 1'b0, 1'b0, tiles);
            for (int i = 0; i < win; i++) expect_cycle(4, lay, 1'b0, 1'b0, tiles);
            expect_cycle(5, lay, 1'b0, 1'b0, tiles);
        end
        expect_cycle(6, 0, 1'b0, 1'b0, tiles);
        for (int i = 0; i < 3; i++) expect_cycle(7, 0, 1'b0, 1'b0, tiles);
        inj_at = -1;
    endtask

    // R1: reset state
    task automatic t_reset();
        @(negedge clk);
        check("R1 reset controls", 128'({cap_rst, acc_clr, vmm_mode, enc_start, integ_win,
              drive_all, acc_en, done, busy}), 128'(0));
        check("R1 reset layer_sel", 128'(layer_sel), 128'(0));
        check("R1 reset tile_en", 128'(tile_en), 128'(0));
    endtask

    // R2 R3 R4: single layer, basic timing
    task automatic t_basic();
        run_op(5, 0, 2, 3, 8, 4'b0101, 4'b0011, -1);
    endtask

    // R7 R8: four layers accumulated
    task automatic t_multi();
        run_op(10, 3, 1, 4, 4, 4'b1111, 4'b0001, -1);
    endtask

    // R7 R4: wrap past the top layer, minimum stretch
    task automatic t_wrap();
        run_op(63, 1, 3, 2, 0, 4'b1000, 4'b1010, -1);
    endtask

    // R5: zero counts treated as one cycle
    task automatic t_zero();
        run_op(0, 0, 0, 0, 15, 4'b0010, 4'b0100, -1);
    endtask

    // R10: a start while busy is ignored
    task automatic t_busy_start();
        run_op(7, 2, 2, 5, 12, 4'b0110, 4'b1001, 8);
    endtask

    // R4: large stretch fraction
    task automatic t_stretch();
        run_op(33, 0, 1, 20, 15, 4'b1111, 4'b1111, -1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_multi();
        t_wrap();
        t_zero();
        t_busy_start();
        t_stretch();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule